// File: doc/BRIEF.md
# Calendar Clock With Alarm

This block keeps the time of day and the calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick` advances the time by one second. The host sees the time through a set of visible byte registers. These are refreshed at the end of a short update window, and `uip` is high for the whole of that window. Each field is shown in BCD or in plain binary, and hours are shown in 24-hour form or in 12-hour form with a PM flag. The host writes a field through a select code. A freeze input lets the host load a whole new time while the visible registers hold still. The new time takes effect when the freeze is released.

A three-field alarm (seconds, minutes, hours) is compared with the freshly encoded time at the end of every update. A field whose two top bits are both set matches any value. The block pulses `upd_done` when an update ends, and it pulses `alarm_hit` in that same cycle when the alarm matches.

The control FSM has three states. IDLE waits for a tick. IDLE goes to HOLD when a tick arrives and `div_ctl` is 3'b010. HOLD counts out `UIP_CYCLES` clocks and then goes to COMMIT. COMMIT lasts one cycle, in which the visible registers are refreshed and the pulses are raised, and then returns to IDLE.

Top module: `cc_calendar_clock`

## Requirements
- R1: Seconds and minutes wrap from 59 to 0 with a carry into the next field. Hours wrap from 23 to 0 with a carry into the day.
- R2: Day of week counts 1 to 7 and goes from 7 back to 1 at midnight.
- R3: Day of month rolls over after 31, 30 or 28 days according to the month. February has 29 days in a leap year. The full year is BASE_CENTURY*100 plus the two-digit year, and the usual 4/100/400 rule applies to it.
- R4: Month counts 1 to 12. Going past 12 gives 1 and increments the year, which wraps from 99 to 0.
- R5: With `bin_mode`=0 each visible field is BCD, with tens in bits 7:4 and units in bits 3:0. With `bin_mode`=1 each field is plain binary. Writes are decoded with the same rule.
- R6: With `hr24`=0 the hour field holds the hour modulo 12, and bit 7 is set for hours 12 to 23. A written hour with bit 7 set is read as a PM hour. With `hr24`=1 the hour field holds 0..23.
- R7: A tick advances the time only when `div_ctl`=3'b010. Any other value ignores the tick: `uip` stays low and the visible time is unchanged.
- R8: While `set_mode`=1, `uip` is low and the visible time registers keep what the host wrote. When `set_mode` falls, the written values become the running time.
- R9: The write select codes are 0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 alarm sec, 8 alarm min, 9 alarm hour. When `set_mode`=0, a write to codes 0..6 takes effect at once, and the next tick advances from the written value.
- R10: `uip` rises on the clock edge that samples an accepted tick and stays high for UIP_CYCLES+1 cycles. In the cycle after it falls, the visible registers hold the new time and `upd_done` is high for exactly one cycle.
- R11: `alarm_hit` pulses together with `upd_done` when `alarm_en`=1 and each alarm field is either a wildcard (bits 7:6 = 2'b11) or equal to the new visible field in its stored format.
- R12: A BCD digit above 9 is accepted without correction. For example, seconds 0x5A decode to 60, and the next tick wraps the field to 0x00 with a carry.
- R13: After reset the visible time reads 00:00:00 with day of week 1, day 1, month 1 and year 0. `uip`, `upd_done` and `alarm_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second advance pulse |
| div_ctl | input | 3 | Divider control; only 3'b010 lets the time run |
| set_mode | input | 1 | Freeze visible registers for loading a time |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| alarm_en | input | 1 | Enables the alarm compare |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select code (see R9) |
| wr_data | input | 8 | Field write value |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible two-digit year |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | Update-ended pulse |
| alarm_hit | output | 1 | Alarm match pulse |

## Verification
The bench builds the block with UIP_CYCLES=3, so each update window lasts four cycles and many ticks fit into a short run. It uses BASE_CENTURY=21, which makes year 00 the year 2100. That year is divisible by 100 but not by 400, so the bench can show that February of year 00 has 28 days while February of year 04 has 29.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cc_time_t;

    // Stored field (BCD or binary) to binary value; BCD digits are not range checked.
    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
        logic [7:0] r;
        r = 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
        return bin ? v : r;
    endfunction

    function automatic logic [7:0] to_enc(input logic [7:0] v, input logic bin);
        logic [7:0] q;
        logic [7:0] r;
        q = v / 8'd10;
        r = v % 8'd10;
        return bin ? v : {q[3:0], r[3:0]};
    endfunction

    function automatic logic [7:0] hour_dec(input logic [7:0] v, input logic bin, input logic h24);
        logic [7:0] h;
        h = to_bin({1'b0, v[6:0]}, bin);
        if (!h24 && v[7]) h = h + 8'd12;
        return h;
    endfunction

    function automatic logic [7:0] hour_enc(input logic [7:0] h, input logic bin, input logic h24);
        logic [7:0] m;
        m = h % 8'd12;
        if (h24) return to_enc(h, bin);
        return to_enc(m, bin) | {(h >= 8'd12), 7'd0};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr,
                                             input int century);
        logic leap;
        leap = (yr[1:0] == 2'b00) && ((yr != 8'd0) || ((century % 4) == 0));
        case (mon)
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    function automatic logic field_hit(input logic [7:0] a, input logic [7:0] v);
        return (a[7:6] == 2'b11) || (a == v);
    endfunction

endpackage

// File: rtl/cc_advance.sv
module cc_advance
    import cc_pkg::*;
#(
    parameter int BASE_CENTURY = 20
) (
    input  cc_time_t cur,
    output cc_time_t nxt
);
    always_comb begin
        nxt     = cur;
        nxt.sec = cur.sec + 8'd1;
        if (nxt.sec >= 8'd60) begin
            nxt.sec = 8'd0;
            nxt.min = cur.min + 8'd1;
            if (nxt.min >= 8'd60) begin
                nxt.min  = 8'd0;
                nxt.hour = cur.hour + 8'd1;
                if (nxt.hour >= 8'd24) begin
                    nxt.hour = 8'd0;
                    nxt.wday = (cur.wday >= 8'd7) ? 8'd1 : cur.wday + 8'd1;
                    nxt.mday = cur.mday + 8'd1;
                    if (nxt.mday > month_len(cur.mon, cur.year, BASE_CENTURY)) begin
                        nxt.mday = 8'd1;
                        nxt.mon  = cur.mon + 8'd1;
                        if (nxt.mon > 8'd12) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cc_codec.sv
module cc_codec
    import cc_pkg::*;
(
    input  cc_time_t bin_in,
    input  cc_time_t vis_in,
    input  logic     bin_mode,
    input  logic     hr24,
    output cc_time_t vis_out,
    output cc_time_t bin_out
);
    always_comb begin
        vis_out.sec  = to_enc(bin_in.sec,  bin_mode);
        vis_out.min  = to_enc(bin_in.min,  bin_mode);
        vis_out.hour = hour_enc(bin_in.hour, bin_mode, hr24);
        vis_out.wday = to_enc(bin_in.wday, bin_mode);
        vis_out.mday = to_enc(bin_in.mday, bin_mode);
        vis_out.mon  = to_enc(bin_in.mon,  bin_mode);
        vis_out.year = to_enc(bin_in.year, bin_mode);

        bin_out.sec  = to_bin(vis_in.sec,  bin_mode);
        bin_out.min  = to_bin(vis_in.min,  bin_mode);
        bin_out.hour = hour_dec(vis_in.hour, bin_mode, hr24);
        bin_out.wday = to_bin(vis_in.wday, bin_mode);
        bin_out.mday = to_bin(vis_in.mday, bin_mode);
        bin_out.mon  = to_bin(vis_in.mon,  bin_mode);
        bin_out.year = to_bin(vis_in.year, bin_mode);
    end
endmodule

// File: rtl/cc_calendar_clock.sv
module cc_calendar_clock
    import cc_pkg::*;
#(
    parameter int UIP_CYCLES   = 8,
    parameter int BASE_CENTURY = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [2:0] div_ctl,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       alarm_en,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip,
    output logic       upd_done,
    output logic       alarm_hit
);
    localparam int CW = $clog2(UIP_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(UIP_CYCLES - 1);
    localparam logic [2:0] RUN_CODE = 3'b010;
    localparam cc_time_t RESET_TIME = '{sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
                                        mday: 8'd1, mon: 8'd1, year: 8'd0};

    typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_COMMIT} cc_state_t;

    cc_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    cc_time_t      tm_q, vis_q, vis_wr, tm_next, tm_dec, tm_enc;
    logic [7:0]    al_sec_q, al_min_q, al_hr_q;
    logic          set_q, wr_time, load, start, match;

    assign start   = (state_q == ST_IDLE) && sec_tick && (div_ctl == RUN_CODE);
    assign wr_time = wr_en && (wr_sel <= 4'd6);
    assign load    = (wr_time && !set_mode) || (set_q && !set_mode);
    assign match   = field_hit(al_sec_q, tm_enc.sec) && field_hit(al_min_q, tm_enc.min)
                   && field_hit(al_hr_q, tm_enc.hour);

    always_comb begin
        vis_wr = vis_q;
        if (wr_en) begin
            unique case (wr_sel)
                4'd0:    vis_wr.sec  = wr_data;
                4'd1:    vis_wr.min  = wr_data;
                4'd2:    vis_wr.hour = wr_data;
                4'd3:    vis_wr.wday = wr_data;
                4'd4:    vis_wr.mday = wr_data;
                4'd5:    vis_wr.mon  = wr_data;
                4'd6:    vis_wr.year = wr_data;
                default: vis_wr = vis_q;
            endcase
        end
    end

    cc_advance #(.BASE_CENTURY(BASE_CENTURY)) u_adv (.cur(tm_q), .nxt(tm_next));

    cc_codec u_codec (
        .bin_in(tm_q), .vis_in(vis_wr), .bin_mode(bin_mode), .hr24(hr24),
        .vis_out(tm_enc), .bin_out(tm_dec)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE:   if (start) begin state_d = ST_HOLD; cnt_d = HOLD_LAST; end
            ST_HOLD:   if (cnt_q == '0) state_d = ST_COMMIT; else cnt_d = cnt_q - 1'b1;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q      <= RESET_TIME;
            vis_q     <= RESET_TIME;
            al_sec_q  <= 8'd0;
            al_min_q  <= 8'd0;
            al_hr_q   <= 8'd0;
            set_q     <= 1'b0;
            uip       <= 1'b0;
            upd_done  <= 1'b0;
            alarm_hit <= 1'b0;
        end else begin
            upd_done  <= 1'b0;
            alarm_hit <= 1'b0;
            set_q     <= set_mode;
            vis_q     <= vis_wr;
            if (wr_en && wr_sel == 4'd7) al_sec_q <= wr_data;
            if (wr_en && wr_sel == 4'd8) al_min_q <= wr_data;
            if (wr_en && wr_sel == 4'd9) al_hr_q  <= wr_data;
            if (load)       tm_q <= tm_dec;
            else if (start) tm_q <= tm_next;
            if (state_q == ST_COMMIT) begin
                if (!set_mode) vis_q <= tm_enc;
                uip       <= 1'b0;
                upd_done  <= 1'b1;
                alarm_hit <= alarm_en && match;
            end else if (start) begin
                uip <= !set_mode;
            end
            if (set_mode) uip <= 1'b0;
        end
    end

    assign sec_o  = vis_q.sec;
    assign min_o  = vis_q.min;
    assign hour_o = vis_q.hour;
    assign wday_o = vis_q.wday;
    assign mday_o = vis_q.mday;
    assign mon_o  = vis_q.mon;
    assign year_o = vis_q.year;

endmodule

// File: rtl/cc_calendar_clock_chk.sv
module cc_calendar_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic [2:0] div_ctl,
    input logic       set_mode,
    input logic       alarm_en,
    input logic       wr_en,
    input logic [7:0] sec_o,
    input logic       uip,
    input logic       upd_done,
    input logic       alarm_hit
);
    assert_sec_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o != $past(sec_o)) |-> (upd_done || $past(wr_en)));

    assert_gated_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && div_ctl != 3'b010 && !uip && !upd_done) |=> !uip);

    assert_freeze_no_uip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !uip);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    assert_uip_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> (upd_done || $past(set_mode)));

    assert_alarm_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);

    assert_alarm_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(alarm_en));
endmodule

bind cc_calendar_clock cc_calendar_clock_chk u_chk (.*);

// File: tb/tb_cc_calendar_clock.sv
`timescale 1ns/1ps
module tb_cc_calendar_clock;
    localparam int UIP  = 3;
    localparam int CENT = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, set_mode = 1'b0, bin_mode = 1'b0, hr24 = 1'b1, alarm_en = 1'b0;
    logic [2:0] div_ctl = 3'b010;
    logic wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
    logic uip, upd_done, alarm_hit;

    int checks = 0, fails = 0;
    int uip_cnt = 0, done_cnt = 0, alarm_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cc_calendar_clock #(.UIP_CYCLES(UIP), .BASE_CENTURY(CENT)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .div_ctl(div_ctl), .set_mode(set_mode),
        .bin_mode(bin_mode), .hr24(hr24), .alarm_en(alarm_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .uip(uip), .upd_done(upd_done),
        .alarm_hit(alarm_hit));

    // ---------------- behavioural reference model ----------------
    int t[7];
    int mv[7];
    int ma[3];
    int busy;
    bit m_uip, m_done, m_alarm, p_set, ld;

    function automatic int dec(int v);
        return bin_mode ? v : ((v / 16) * 10 + (v % 16));
    endfunction
    function automatic int enc(int v);
        return bin_mode ? v : ((((v / 10) % 16) * 16) + (v % 10));
    endfunction
    function automatic int hdec(int v);
        int h;
        h = dec(v % 128);
        if (!hr24 && v >= 128) h += 12;
        return h;
    endfunction
    function automatic int henc(int h);
        if (hr24) return enc(h);
        return enc(h % 12) + ((h >= 12) ? 128 : 0);
    endfunction
    function automatic int mlen(int mo, int yr);
        int full;
        full = CENT * 100 + yr;
        if (mo == 2) return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic bit fhit(int a, int v);
        return ((a & 'hC0) == 'hC0) || (a == v);
    endfunction

    task automatic m_advance();
        t[0]++;
        if (t[0] >= 60) begin
            t[0] = 0; t[1]++;
            if (t[1] >= 60) begin
                t[1] = 0; t[2]++;
                if (t[2] >= 24) begin
                    int lim;
                    lim = mlen(t[5], t[6]);
                    t[2] = 0;
                    t[3] = (t[3] >= 7) ? 1 : t[3] + 1;
                    t[4]++;
                    if (t[4] > lim) begin
                        t[4] = 1; t[5]++;
                        if (t[5] > 12) begin t[5] = 1; t[6] = (t[6] >= 99) ? 0 : t[6] + 1; end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            t = '{0, 0, 0, 1, 1, 1, 0};
            mv = '{0, 0, 0, 1, 1, 1, 0};
            ma = '{0, 0, 0};
            busy = 0; m_uip = 0; m_done = 0; m_alarm = 0; p_set = 0;
        end else begin
            m_done = 0; m_alarm = 0;
            ld = (wr_en && wr_sel <= 6 && !set_mode) || (p_set && !set_mode);
            if (wr_en) begin
                if (wr_sel <= 6) mv[wr_sel] = int'(wr_data);
                else if (wr_sel <= 9) ma[wr_sel - 7] = int'(wr_data);
            end
            if (busy > 0) begin
                busy--;
                if (busy == 0) begin
                    m_alarm = alarm_en && fhit(ma[0], enc(t[0])) && fhit(ma[1], enc(t[1]))
                              && fhit(ma[2], henc(t[2]));
                    if (!set_mode) begin
                        mv[0] = enc(t[0]); mv[1] = enc(t[1]); mv[2] = henc(t[2]);
                        mv[3] = enc(t[3]); mv[4] = enc(t[4]); mv[5] = enc(t[5]); mv[6] = enc(t[6]);
                    end
                    m_uip = 0; m_done = 1;
                end
            end else if (sec_tick && div_ctl == 3'b010) begin
                if (!ld) m_advance();
                busy = UIP + 1;
                m_uip = !set_mode;
            end
            if (ld) begin
                t[0] = dec(mv[0]); t[1] = dec(mv[1]); t[2] = hdec(mv[2]);
                t[3] = dec(mv[3]); t[4] = dec(mv[4]); t[5] = dec(mv[5]); t[6] = dec(mv[6]);
            end
            if (set_mode) m_uip = 0;
            p_set = set_mode;
        end
    end

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R1 sec", sec_o, mv[0]);
            cmp("R1 min", min_o, mv[1]);
            cmp("R1 hour", hour_o, mv[2]);
            cmp("R2 wday", wday_o, mv[3]);
            cmp("R3 mday", mday_o, mv[4]);
            cmp("R4 month", mon_o, mv[5]);
            cmp("R4 year", year_o, mv[6]);
            cmp("R10 uip", uip, m_uip);
            cmp("R10 upd_done", upd_done, m_done);
            cmp("R11 alarm_hit", alarm_hit, m_alarm);
            if (uip) uip_cnt++;
            if (upd_done) done_cnt++;
            if (alarm_hit) alarm_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick(output int du, output int dd, output int da);
        int u0, d0, a0;
        u0 = uip_cnt; d0 = done_cnt; a0 = alarm_cnt;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (UIP + 4) @(negedge clk);
        du = uip_cnt - u0; dd = done_cnt - d0; da = alarm_cnt - a0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y);
        @(negedge clk); set_mode = 1'b1;
        wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h); wr(4'd3, wd);
        wr(4'd4, md); wr(4'd5, mo); wr(4'd6, y);
        @(negedge clk); set_mode = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int du, dd, da;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        cmp("R13 reset sec", sec_o, 8'h00);
        cmp("R13 reset wday", wday_o, 8'h01);
        cmp("R13 reset month", mon_o, 8'h01);
        cmp("R13 reset uip", uip, 0);

        // R8 freeze: tick while set_mode holds written values and no uip
        @(negedge clk); set_mode = 1'b1;
        wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h23); wr(4'd3, 8'h07);
        wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
        tick(du, dd, da);
        cmp("R8 frozen sec", sec_o, 8'h58);
        cmp("R8 no uip in freeze", du, 0);
        @(negedge clk); set_mode = 1'b0;
        repeat (2) @(negedge clk);
        tick(du, dd, da);
        cmp("R8 loaded on release", sec_o, 8'h59);
        // R1 R2 R4 full rollover to year 00
        tick(du, dd, da);
        cmp("R1 sec wrap", sec_o, 8'h00);
        cmp("R1 hour wrap", hour_o, 8'h00);
        cmp("R2 wday wrap", wday_o, 8'h01);
        cmp("R4 month wrap", mon_o, 8'h01);
        cmp("R4 year wrap", year_o, 8'h00);

        // R3 month lengths and century rule
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
        tick(du, dd, da);
        cmp("R3 feb year00 not leap mday", mday_o, 8'h01);
        cmp("R3 feb year00 not leap mon", mon_o, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h04);
        tick(du, dd, da);
        cmp("R3 feb leap", mday_o, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
        tick(du, dd, da);
        cmp("R3 april end", mon_o, 8'h05);

        // R5 binary mode
        bin_mode = 1'b1;
        set_time(8'd45, 8'd10, 8'd5, 8'd3, 8'd9, 8'd6, 8'd20);
        tick(du, dd, da);
        cmp("R5 binary sec", sec_o, 8'd46);
        bin_mode = 1'b0;

        // R6 12-hour mode
        hr24 = 1'b0;
        set_time(8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h03, 8'h21);
        tick(du, dd, da);
        cmp("R6 11pm to midnight", hour_o, 8'h00);
        cmp("R6 day advanced", mday_o, 8'h16);
        set_time(8'h59, 8'h59, 8'h11, 8'h01, 8'h15, 8'h03, 8'h21);
        tick(du, dd, da);
        cmp("R6 noon has PM flag", hour_o, 8'h80);
        hr24 = 1'b1;
        set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h15, 8'h03, 8'h21);

        // R7 divider gate
        div_ctl = 3'b011;
        tick(du, dd, da);
        cmp("R7 gated sec", sec_o, 8'h00);
        cmp("R7 gated uip", du, 0);
        div_ctl = 3'b010;

        // R9 direct write, R10 update window
        wr(4'd0, 8'h30);
        @(negedge clk);
        cmp("R9 direct write visible", sec_o, 8'h30);
        tick(du, dd, da);
        cmp("R9 advance from written", sec_o, 8'h31);
        cmp("R10 uip length", du, UIP + 1);
        cmp("R10 one done pulse", dd, 1);

        // R11 alarm
        alarm_en = 1'b1;
        wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
        tick(du, dd, da);
        cmp("R11 wildcard alarm", da, 1);
        wr(4'd7, 8'h34);
        tick(du, dd, da);
        cmp("R11 seconds mismatch", da, 0);
        tick(du, dd, da);
        cmp("R11 seconds match", da, 1);
        wr(4'd9, 8'h10);
        wr(4'd7, 8'hC0);
        tick(du, dd, da);
        cmp("R11 exact hour match", da, 1);
        alarm_en = 1'b0;
        tick(du, dd, da);
        cmp("R11 disabled", da, 0);

        // R12 out-of-range BCD digit
        wr(4'd0, 8'h5A);
        tick(du, dd, da);
        cmp("R12 sec normalised", sec_o, 8'h00);
        cmp("R12 minute carry", min_o, 8'h01);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule